// File: doc/BRIEF.md
# Serial Control Port Register Slave

A three-wire serial slave that gives a host write and read access to a bank of 8-bit mode registers. The host pulls the active-low select `cs_n` low, clocks sixteen bits on `sdi` with `sck`, and raises `cs_n` again. The block brings all three lines into its own system clock through synchronisers and finds their edges there. It shifts in each frame and commits write frames when the select line rises. The whole register bank is visible at all times on a flat parallel output.

A frame carries a read/write flag, a 7-bit register index and a data byte. A write frame stores the byte at the index. A read frame does not use its index. Instead it returns the register named by the pointer field of register 11. During the first half of the frame `sdo` is not driven. During the second half the selected byte is shifted out on `sdo`, with `sdo_oe` high.

Top module: `ctrl_port_slave`

## Requirements
- R1: After reset every register reads 0x00 on `reg_q` and `sdo_oe` is low.
- R2: A frame is 16 bits sent most significant bit first on `sdi`, sampled at rising `sck` while `cs_n` is low. Bit 15 is the direction flag (0 = write, 1 = read), bits 14..8 are the register index and bits 7..0 are the data byte.
- R3: When `cs_n` rises after exactly 16 bits of a write frame, the data byte is stored in the indexed register, and it appears on `reg_q[8*i +: 8]`.
- R4: If `cs_n` rises after fewer than 16 bits, the frame is dropped and no register changes.
- R5: `sck` rising edges after the sixteenth are ignored: the first 16 bits decide the frame.
- R6: A read frame ignores its index and data fields. It returns the register whose number is held in bits 6..0 of register 11, and it changes no register.
- R7: In a read frame, `sdo_oe` stays low during the first 8 bits. After the falling `sck` edges that follow bits 8 to 15, the block drives data bits 7 down to 0 on `sdo`, so the host samples them at rising edges 9 to 16.
- R8: When `cs_n` goes high, `sdo_oe` drops within 4 system clock cycles, whether or not the frame was complete.
- R9: Bit 7 of register 11 is an auto-increment mode flag. It is stored and read back like any other bit. When it is clear, register 11 selects a single register; setting it does not change which register a read returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, idles high |
| sck | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data, valid while `sdo_oe` is high |
| sdo_oe | output | 1 | Output enable for `sdo` (low = high impedance) |
| reg_q | output | NUM_REGS*8 | All registers, register i at bits 8*i+7..8*i |

## Verification
A port change reaches the synchronised level after two system clock edges, and the block acts on it at the third edge. A committed write shows on `reg_q` one edge later, so the bench checks `reg_q` eight cycles after `cs_n` rises. It checks `sdo_oe` for release five cycles after that rise. The host model holds each `sck` phase for eight system cycles, so `sdo` has settled about three cycles after a falling edge. The bench samples `sdo` and `sdo_oe` on the system cycle in which it raises `sck`. Read results go through a scoreboard queue: the driver pushes the expected byte before the frame, and a monitor pops and compares it when the frame ends.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int LEAD_BITS  = FRAME_BITS - DATA_W;

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] index;
    logic [DATA_W-1:0] payload;
  } frame_t;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] prev
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES:0] chain_q;
      logic [STAGES:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-1:0], din[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){RST_VAL[g]}};
        else        chain_q <= chain_d;
      end
      assign lvl[g]  = chain_q[STAGES-1];
      assign prev[g] = chain_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/cps_deframer.sv
module cps_deframer
  import cps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sel_rise,
  input  logic              sclk_rise,
  input  logic              sdi_lvl,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              rd_frame
);
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sreg_q, sreg_d;
  logic                  rd_q, rd_d;
  logic                  wr_q, wr_d;
  logic [ADDR_W-1:0]     addr_q, addr_d;
  logic [DATA_W-1:0]     data_q, data_d;
  frame_t                frm;
  logic                  full;

  assign frm  = frame_t'(sreg_q);
  assign full = (cnt_q == CNT_W'(FRAME_BITS));

  always_comb begin
    cnt_d  = cnt_q;
    sreg_d = sreg_q;
    rd_d   = rd_q;
    wr_d   = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (sel_lvl) begin
      cnt_d = '0;
      rd_d  = 1'b0;
      if (sel_rise && full && !frm.is_read) begin
        wr_d   = 1'b1;
        addr_d = frm.index;
        data_d = frm.payload;
      end
    end else if (sclk_rise && !full) begin
      sreg_d = {sreg_q[FRAME_BITS-2:0], sdi_lvl};
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == '0) rd_d = sdi_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sreg_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_en    = wr_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign bit_cnt  = cnt_q;
  assign rd_frame = rd_q;

  // R5: the bit counter saturates at one frame
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_BITS));

  // R4: a select rise on a partial frame never commits
  p_short_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && !full) |=> !wr_q);

  // R3: a commit only follows a select rise
  p_commit_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(sel_rise));

  // R6: read frames never commit
  p_read_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && rd_q) |=> !wr_q);
endmodule

// File: rtl/cps_reg_bank.sv
module cps_reg_bank
  import cps_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int PTR_REG  = 11,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_REGS*DATA_W-1:0] reg_flat,
  output logic [DATA_W-1:0]        rd_byte
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [ADDR_W-1:0] rd_idx;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic              we;
      logic [DATA_W-1:0] d;
      always_comb begin
        we = wr_en && (wr_addr == ADDR_W'(g));
        d  = we ? wr_data : regs_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[g] <= '0;
        else        regs_q[g] <= d;
      end
      assign reg_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end
  endgenerate

  assign rd_idx = regs_q[PTR_REG][ADDR_W-1:0];

  always_comb begin
    if (int'(rd_idx) < NUM_REGS) rd_byte = regs_q[rd_idx[IDX_W-1:0]];
    else                         rd_byte = '0;
  end

  // R3: a commit lands in the addressed register
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) < NUM_REGS) |=>
      regs_q[$past(wr_addr[IDX_W-1:0])] == $past(wr_data));

  // R6: with no commit the bank holds still
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_flat));
endmodule

// File: rtl/cps_readout.sv
module cps_readout
  import cps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sclk_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              rd_frame,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sdo,
  output logic              sdo_oe
);
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              at_load, in_data;

  assign at_load = (bit_cnt == CNT_W'(LEAD_BITS));
  assign in_data = (bit_cnt > CNT_W'(LEAD_BITS)) && (bit_cnt < CNT_W'(FRAME_BITS));

  always_comb begin
    oe_d = oe_q;
    sh_d = sh_q;
    if (sel_lvl) begin
      oe_d = 1'b0;
    end else if (sclk_fall && rd_frame) begin
      if (at_load) begin
        oe_d = 1'b1;
        sh_d = rd_byte;
      end else if (oe_q && in_data) begin
        sh_d = {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      sh_q <= '0;
    end else begin
      oe_q <= oe_d;
      sh_q <= sh_d;
    end
  end

  assign sdo    = sh_q[DATA_W-1];
  assign sdo_oe = oe_q;

  // R7: output turns on only at the end of the lead bits
  p_oe_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (bit_cnt == CNT_W'(LEAD_BITS)));

  // R7: output is only driven in a read frame
  p_oe_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> rd_frame);

  // R8: select high releases the output
  p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lvl |=> !oe_q);
endmodule

// File: rtl/ctrl_port_slave.sv
module ctrl_port_slave
  import cps_pkg::*;
#(
  parameter int NUM_REGS    = 128,
  parameter int PTR_REG     = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sck,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_oe,
  output logic [NUM_REGS*DATA_W-1:0] reg_q
);
  localparam int B_SEL = 0;
  localparam int B_SCK = 1;
  localparam int B_SDI = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [2:0] s_lvl, s_prev;
  logic       sel_rise, sclk_rise, sclk_fall;

  cps_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({sdi, sck, cs_n}),
    .lvl  (s_lvl),
    .prev (s_prev)
  );

  assign sel_rise  =  s_lvl[B_SEL] & ~s_prev[B_SEL];
  assign sclk_rise =  s_lvl[B_SCK] & ~s_prev[B_SCK];
  assign sclk_fall = ~s_lvl[B_SCK] &  s_prev[B_SCK];

  logic              wr_en, rd_frame;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, rd_byte;
  logic [CNT_W-1:0]  bit_cnt;

  cps_deframer u_deframer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_lvl  (s_lvl[B_SEL]),
    .sel_rise (sel_rise),
    .sclk_rise(sclk_rise),
    .sdi_lvl  (s_lvl[B_SDI]),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bit_cnt  (bit_cnt),
    .rd_frame (rd_frame)
  );

  cps_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_REG(PTR_REG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .reg_flat(reg_q),
    .rd_byte (rd_byte)
  );

  cps_readout u_readout (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_lvl  (s_lvl[B_SEL]),
    .sclk_fall(sclk_fall),
    .bit_cnt  (bit_cnt),
    .rd_frame (rd_frame),
    .rd_byte  (rd_byte),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );
endmodule

// File: tb/ctrl_port_slave_tb.sv
module ctrl_port_slave_tb;
  localparam int NREG = 128;
  localparam int HALF = 8;

  logic clk, rst_n, cs_n, sck, sdi, sdo, sdo_oe;
  logic [NREG*8-1:0] reg_q;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [NREG];
  logic [7:0] exp_q [$];
  logic [7:0] got_byte;
  event rd_done;

  ctrl_port_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_q(reg_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_bank(input string req);
    int bad = -1;
    checks++;
    for (int i = 0; i < NREG; i++)
      if (bad < 0 && reg_q[i*8 +: 8] !== model[i]) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s reg %0d: got %0h expected %0h", req, bad,
               reg_q[bad*8 +: 8], model[bad]);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Host model: nbits sck pulses, returns bits seen on sdo in the data half
  task automatic send_frame(input logic [15:0] w, input int nbits,
                            output logic [7:0] rx, output int early_oe,
                            output int late_oe);
    rx = '0; early_oe = 0; late_oe = 0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int b = 0; b < nbits; b++) begin
      sdi = (b < 16) ? w[15-b] : 1'b1;
      wait_clk(HALF);
      if (b < 8 && sdo_oe) early_oe++;
      if (b >= 8 && b < 16) begin
        if (sdo_oe) late_oe++;
        rx = {rx[6:0], sdo};
      end
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(5);
    check("R8", "sdo_oe after cs_n high", int'(sdo_oe), 0);
    wait_clk(3);
  endtask

  task automatic write_reg(input string req, input int addr, input int data,
                           input int nbits);
    logic [7:0] rx;
    int e, l;
    send_frame({1'b0, 7'(addr), 8'(data)}, nbits, rx, e, l);
    if (nbits >= 16) model[addr] = 8'(data);
    check_bank(req);
  endtask

  task automatic read_reg(input string req, input int junk, input logic [7:0] exp);
    logic [7:0] rx;
    int e, l;
    exp_q.push_back(exp);
    send_frame({1'b1, 7'(junk), 8'(junk)}, 16, rx, e, l);
    check("R7", "sdo_oe during lead bits", e, 0);
    check("R7", "sdo_oe during data bits", l, 8);
    check_bank("R6 read leaves bank");
    got_byte = rx;
    ->rd_done;
    wait_clk(1);
  endtask

  // Monitor: compares each completed read with the scoreboard head
  initial begin
    forever begin
      @(rd_done);
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected read: got %0h expected none", got_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (got_byte !== e) begin
          fails++;
          $display("FAIL R6 read data: got %0h expected %0h", got_byte, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int e, l;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);

    // R1 reset state
    check_bank("R1");
    check("R1", "sdo_oe at reset", int'(sdo_oe), 0);

    // R2 / R3 writes with distinct bit patterns
    write_reg("R2 R3", 5, 8'hA5, 16);
    write_reg("R3", 127, 8'h3C, 16);
    write_reg("R3", 0, 8'hFF, 16);
    write_reg("R2", 64, 8'h01, 16);

    // R6 read via pointer, index field ignored
    write_reg("R6", 11, 8'h05, 16);
    read_reg("R6", 7'h7F, 8'hA5);
    write_reg("R6", 11, 8'h40, 16);
    read_reg("R6", 7'h05, 8'h01);

    // R4 short frames dropped
    write_reg("R4", 20, 8'h55, 12);
    write_reg("R4", 21, 8'hAA, 15);

    // R5 extra clocks ignored
    write_reg("R5", 30, 8'h81, 20);

    // R9 flag bit kept, selection unchanged
    write_reg("R9", 11, 8'hFF, 16);
    check("R9", "flag bit stored", int'(reg_q[11*8+7]), 1);
    read_reg("R9", 7'h00, 8'h3C);
    write_reg("R9", 11, 8'h0B, 16);
    read_reg("R9", 7'h33, 8'h0B);

    // R8 aborted read releases sdo and changes nothing
    send_frame({1'b1, 7'h00, 8'h00}, 11, rx, e, l);
    check("R8", "oe during aborted read", l, 3);
    check_bank("R8 aborted read");

    check("R6", "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule